// File: doc/BRIEF.md
# PSK Phase Accumulator Modulator

This block is the phase generator at the front of a digital phase-shift-keyed transmitter. An N-bit accumulator adds a frequency control word on every clock and wraps modulo 2^N, so the carrier frequency is `fcw * fclk / 2^N` and the frequency step is `fclk / 2^N`. The top M bits of the accumulator form a phase word that will later address a sine lookup stage. Symbol data turns this word into a modulated phase by adding an offset to it. In binary mode one data bit flips the phase by half a turn. In quadrature mode two data bits move the phase by a whole number of quarter turns. The data only changes the phase word. It never touches the accumulator or the frequency word.

Truncating N bits down to M drops low bits, and those dropped bits show up as phase jitter. When noise shaping is enabled, a first-order error-feedback loop adds the low bits left over from the previous cycle to the next value before it is truncated. This pushes the quantization error towards high frequencies. The phase word and its valid strobe come from registers, one clock after the inputs are sampled.

Top module: `psk_phase_mod`

## Requirements
- R1: On every clock edge with reset low, the accumulator becomes (accumulator + `fcw`) mod 2^ACC_W.
- R2: With shaping off and no offset, `phase` equals the top PH_W bits of the updated accumulator, truncated and not rounded.
- R3: When `mode` = 0 (binary), `sym[0]` = 1 inverts the MSB of the phase word, `sym[0]` = 0 leaves it as it is, and `sym[1]` has no effect.
- R4: When `mode` = 1 (quadrature), the value k of `sym[1:0]` adds k * 2^(PH_W-2) to the phase word modulo 2^PH_W. So 0 gives 0, 1 gives a quarter turn, 2 gives a half turn and 3 gives three quarters.
- R5: The offset never reaches the accumulator. After data returns to zero, `phase` continues exactly as the unmodulated carrier would have.
- R6: `fcw`, `mode`, `sym` and `shape_en` are all sampled on the same clock edge. `phase` and `phase_vld` show the result of that edge, so the latency is fixed at one clock.
- R7: With `shape_en` = 1, the value truncated is (new accumulator + stored residue) mod 2^ACC_W, and its low ACC_W-PH_W bits become the stored residue for the next cycle. With `shape_en` = 0, the residue is not added and the stored residue is cleared to zero.
- R8: While `rst` is high at a clock edge, the accumulator, the residue, `phase` and `phase_vld` are cleared to zero. The first edge after reset loads the accumulator with `fcw`.
- R9: `phase_vld` is 1 after every edge at which `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw | input | ACC_W | Frequency control word |
| mode | input | 1 | 0 = binary, 1 = quadrature |
| sym | input | 2 | Symbol data bits |
| shape_en | input | 1 | Enables error-feedback noise shaping |
| phase | output | PH_W | Modulated, truncated phase word |
| phase_vld | output | 1 | Phase word valid strobe |

## Verification
The bench goes after accumulator wrap-around with words close to 2^ACC_W. A design that dropped the carry or saturated the sum would jump the phase instead of wrapping it. It drives words just under one phase LSB: a design that rounded instead of truncating would report the next phase step one cycle early. It toggles symbols and then returns them to zero, and also sends binary symbols with `sym[1]` set. These catch an offset leaking into the accumulator, a wrong quarter-turn step, or a stray bit changing the binary phase. The bench switches shaping on and off in the middle of a run and resets in the middle of a run. A residue that is not cleared, or state that survives reset, shows up as a one-LSB phase error on the cycles that follow.

// File: rtl/psk_pkg.sv
package psk_pkg;
  typedef enum logic {
    MOD_BPSK = 1'b0,
    MOD_QPSK = 1'b1
  } psk_mode_e;
endpackage

// File: rtl/psk_phase_acc.sv
// Phase accumulator with optional first-order error-feedback truncation.
// trunc_nxt is the truncated phase belonging to the value loaded at the next edge.
module psk_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] fcw,
  input  logic             shape_en,
  output logic [PH_W-1:0]  trunc_nxt
);
  localparam int LOW_W = ACC_W - PH_W;

  logic [ACC_W-1:0] acc_q;
  logic [LOW_W-1:0] err_q;
  logic [ACC_W-1:0] acc_nxt;
  logic [ACC_W-1:0] shaped_nxt;
  logic [LOW_W-1:0] err_nxt;

  function automatic logic [ACC_W-1:0] wrap_add(input logic [ACC_W-1:0] a,
                                                 input logic [ACC_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [ACC_W-1:0] feed_residue(input logic [ACC_W-1:0] v,
                                                     input logic [LOW_W-1:0] r,
                                                     input logic en);
    logic [ACC_W-1:0] ext;
    ext = {{PH_W{1'b0}}, r};
    return en ? (v + ext) : v;
  endfunction

  always_comb begin
    acc_nxt    = wrap_add(acc_q, fcw);
    shaped_nxt = feed_residue(acc_nxt, err_q, shape_en);
    err_nxt    = shape_en ? shaped_nxt[LOW_W-1:0] : '0;
    trunc_nxt  = shaped_nxt[ACC_W-1:LOW_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      err_q <= '0;
    end else begin
      acc_q <= acc_nxt;
      err_q <= err_nxt;
    end
  end

  // R1: accumulator advances by the sampled word, modulo 2^ACC_W
  assert_acc_step_R1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> acc_q == $past(acc_q) + $past(fcw));

  // R7: residue is cleared whenever shaping is off
  assert_err_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !shape_en |=> err_q == '0);
endmodule

// File: rtl/psk_offset.sv
// Data-driven phase offset applied to the truncated phase word.
module psk_offset
  import psk_pkg::*;
#(
  parameter int PH_W = 12
) (
  input  logic [PH_W-1:0] ph_in,
  input  psk_mode_e       mode,
  input  logic [1:0]      sym,
  output logic [PH_W-1:0] ph_out
);
  function automatic logic [PH_W-1:0] bpsk_flip(input logic [PH_W-1:0] p,
                                                 input logic b);
    return p ^ {b, {(PH_W-1){1'b0}}};
  endfunction

  function automatic logic [PH_W-1:0] qpsk_rotate(input logic [PH_W-1:0] p,
                                                   input logic [1:0] q);
    return p + {q, {(PH_W-2){1'b0}}};
  endfunction

  always_comb begin
    if (mode == MOD_QPSK) ph_out = qpsk_rotate(ph_in, sym);
    else                  ph_out = bpsk_flip(ph_in, sym[0]);
  end
endmodule

// File: rtl/psk_phase_mod.sv
module psk_phase_mod
  import psk_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] fcw,
  input  logic             mode,
  input  logic [1:0]       sym,
  input  logic             shape_en,
  output logic [PH_W-1:0]  phase,
  output logic             phase_vld
);
  generate
    if (PH_W < 12 || PH_W > 16 || PH_W >= ACC_W) begin : g_bad_widths
      $error("psk_phase_mod: PH_W must be 12..16 and below ACC_W");
    end
  endgenerate

  psk_mode_e       mode_e;
  logic [PH_W-1:0] trunc_w;
  logic [PH_W-1:0] mod_w;
  logic [PH_W-1:0] phase_q;
  logic            vld_q;

  assign mode_e = psk_mode_e'(mode);

  psk_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .fcw       (fcw),
    .shape_en  (shape_en),
    .trunc_nxt (trunc_w)
  );

  psk_offset #(.PH_W(PH_W)) u_off (
    .ph_in  (trunc_w),
    .mode   (mode_e),
    .sym    (sym),
    .ph_out (mod_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= mod_w;
      vld_q   <= 1'b1;
    end
  end

  assign phase     = phase_q;
  assign phase_vld = vld_q;

  // R9: strobe follows every non-reset edge
  assert_vld_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> phase_vld);

  // R3 / R4: offsets never touch the bits below the top two
  assert_low_bits_R4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> phase[PH_W-3:0] == $past(trunc_w[PH_W-3:0]));

  // R3: binary mode with data 0 passes the truncated phase unchanged
  assert_bpsk_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (!mode && !sym[0]) |=> phase == $past(trunc_w));

  // R3: binary mode with data 1 differs only in the MSB
  assert_bpsk_flip_R3: assert property (@(posedge clk) disable iff (rst)
    (!mode && sym[0]) |=> (phase ^ $past(trunc_w)) == {1'b1, {(PH_W-1){1'b0}}});
endmodule

// File: tb/test_psk_phase_mod.sv
module test_psk_phase_mod;
  localparam int N = 32;
  localparam int M = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] fcw = '0;
  logic         mode = 1'b0;
  logic [1:0]   sym = 2'b00;
  logic         shape_en = 1'b0;
  logic [M-1:0] phase;
  logic         phase_vld;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  longint unsigned m_acc = 0, m_err = 0, exp_ph = 0;
  bit exp_vld = 0;
  logic [31:0] lf = 32'hACE1_2468;

  always #10 clk = ~clk;

  psk_phase_mod #(.ACC_W(N), .PH_W(M)) i_psk_phase_mod (
    .clk(clk), .rst(rst), .fcw(fcw), .mode(mode), .sym(sym),
    .shape_en(shape_en), .phase(phase), .phase_vld(phase_vld)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cycles);
      summary();
    end
  end

  // Behavioural reference: state after the coming clock edge
  task automatic model(input bit r, input longint unsigned f, input bit md,
                       input int sy, input bit sh);
    longint unsigned mask, lmask, s, t;
    mask  = (64'd1 << N) - 1;
    lmask = (64'd1 << (N - M)) - 1;
    if (r) begin
      m_acc = 0; m_err = 0; exp_ph = 0; exp_vld = 0;
    end else begin
      m_acc = (m_acc + f) & mask;
      s = sh ? ((m_acc + m_err) & mask) : m_acc;
      t = s >> (N - M);
      if (!md) t = t ^ (longint'(sy % 2) << (M - 1));
      else     t = (t + longint'(sy) * (64'd1 << (M - 2))) % (64'd1 << M);
      m_err  = sh ? (s & lmask) : 0;
      exp_ph = t;
      exp_vld = 1;
    end
  endtask

  task automatic step(input bit r, input logic [N-1:0] f, input bit md,
                      input logic [1:0] sy, input bit sh, input string req);
    rst = r; fcw = f; mode = md; sym = sy; shape_en = sh;
    model(r, longint'(f), md, int'(sy), sh);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (phase !== M'(exp_ph) || phase_vld !== exp_vld) begin
      fails++;
      $display("FAIL %s: actual phase %h vld %b, expected phase %h vld %b",
               req, phase, phase_vld, M'(exp_ph), exp_vld);
    end
  endtask

  initial begin
    @(negedge clk);
    // R8: reset state
    repeat (3) step(1, 32'h0010_0000, 0, 2'b00, 0, "R8 reset");
    // R1 R2 R6 R9: plain carrier, one phase LSB per clock, first edge loads fcw
    repeat (8) step(0, 32'h0010_0000, 0, 2'b00, 0, "R1 R2 R6 R9 carrier");
    // R2: truncation, not rounding
    step(1, 32'h0, 0, 2'b00, 0, "R8 reset");
    repeat (3) step(0, 32'h000F_FFFF, 0, 2'b00, 0, "R2 truncate");
    // R3: binary offsets, sym[1] ignored
    for (int i = 0; i < 8; i++)
      step(0, 32'h0123_4567, 0, 2'(i), 0, "R3 binary");
    // R4: quadrature quarter turns
    for (int i = 0; i < 12; i++)
      step(0, 32'h0123_4567, 1, 2'(i), 0, "R4 quadrature");
    // R5: data back to zero, carrier continues
    repeat (6) step(0, 32'h0123_4567, 0, 2'b00, 0, "R5 carrier intact");
    // R1: wrap-around with large words
    repeat (10) step(0, 32'hFFF0_0000, 0, 2'b00, 0, "R1 wrap down");
    repeat (10) step(0, 32'h7FFF_FFFF, 1, 2'b10, 0, "R1 wrap large");
    repeat (10) step(0, 32'hFFFF_FFFF, 0, 2'b01, 0, "R1 wrap full");
    // R7: shaping on, off, and on again in quadrature
    repeat (40) step(0, 32'h0005_5555, 0, 2'b00, 1, "R7 shaping on");
    repeat (10) step(0, 32'h0005_5555, 0, 2'b00, 0, "R7 residue cleared");
    repeat (30) step(0, 32'h0003_3333, 1, 2'b11, 1, "R7 shaping quadrature");
    // R8: reset in the middle of a run clears all state
    step(1, 32'h0003_3333, 1, 2'b11, 1, "R8 mid reset");
    repeat (5) step(0, 32'h0003_3333, 0, 2'b00, 1, "R8 restart");
    // R6: every input changing every cycle
    for (int i = 0; i < 300; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step((lf[7:0] == 8'h00), {lf[15:0], lf[31:16]}, lf[3], lf[5:4], lf[9],
           "R6 random inputs");
    end
    done = 1;
    summary();
  end
endmodule